// File: doc/BRIEF.md
# Serial Debug Link Host Command Engine

This block is the host-side master of a 17-bit synchronous serial debug link. A requester hands it one high-level operation: a memory read or write of a byte, word or long, a register read or write, a resume, or a peripheral reset. The engine expands that operation into a command word followed by address and data extension words, shifts each word out MSB first on `dsi` while generating the serial clock `dsclk`, and captures the 17-bit frame that the target returns on `dso` during every transfer.

The link is full duplex with a one-word lag, so a frame received while the outgoing words are still being shipped belongs to an earlier word and is discarded. Once the last outgoing word is gone, the engine sends null words and classifies each reply. A reply may carry data, signal completion, ask for another poll (not ready), report a bus error or reject the command as illegal. Read data is assembled and returned with a two-bit status. Not-ready replies are polled again up to a parameterised limit, and past that limit the request ends with a timeout.

Top module: `dlink_host`

## Requirements
- R1: After reset and whenever no request is in progress, `dsclk` is high, `req_ready` is high and `rsp_valid` is low.
- R2: Every frame is 17 bits, shifted MSB first, with its top bit (bit 16) zero. `dsi` changes only when `dsclk` falls, and each low phase and each high phase of `dsclk` lasts `cfg_half`+1 clock cycles.
- R3: A memory read (`req_op`=0) sends the command 0x1900 OR a size code, then the address high half, then the address low half. The size code is 0x00 for byte (`req_size`=0), 0x40 for word (1) and 0x80 for long (2).
- R4: A memory write (`req_op`=1) sends 0x1800 OR the size code, then both address halves, then the data. A byte write sends one word {8'h00, wdata[7:0]}, a word write sends one word wdata[15:0], and a long write sends wdata[31:16] and then wdata[15:0].
- R5: A register read (`req_op`=2) sends the single word 0x2180 OR `req_reg`. A register write (`req_op`=3) sends 0x2080 OR `req_reg`, then wdata[31:16], then wdata[15:0].
- R6: A resume (`req_op`=4) sends the single word 0x0C00 and then ends with status OK, without polling. A peripheral reset (`req_op`=5) sends 0x0400 and then waits for completion.
- R7: Frames received while command and extension words are sent are ignored. After the last of them, each further word sent is the null word 0x0000.
- R8: On a read, the first data reply gives bits 31:16 of the result and the second gives bits 15:0 (long memory and register reads). A word read is zero-extended, and a byte read returns the low 8 bits of its reply.
- R9: On a write, register write or peripheral reset, the first polled reply with bit 16 clear ends the request with status OK (0).
- R10: A reply of 1_0000 (not ready) causes another null word to be sent and the reply to be read again, with no status returned.
- R11: After RETRY_LIMIT consecutive not-ready replies for one expected reply, the next not-ready reply ends the request with status 3 (timeout).
- R12: A reply of 1_0001 ends the request with status 1 (bus error). Any other reply with bit 16 set ends it with status 2 (illegal). On every non-OK status `rsp_rdata` is zero.
- R13: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low until the result is given, and `rsp_valid` is then high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | DLY_W | Serial clock phase length minus one, in clock cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_op | input | 3 | 0 mem read, 1 mem write, 2 reg read, 3 reg write, 4 resume, 5 peripheral reset; 6 and 7 send one null word |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| req_reg | input | 4 | Register number for register operations |
| req_addr | input | 32 | Memory address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_status | output | 2 | 0 OK, 1 bus error, 2 illegal, 3 timeout |
| rsp_rdata | output | 32 | Read result |
| dsclk | output | 1 | Serial clock to target, idles high |
| dsi | output | 1 | Serial data to target |
| dso | input | 1 | Serial data from target |

## Verification
A wrong word index or a wrong plan shows up within one frame: the command or extension word that the target model captures is wrong, or the number of frames differs. A stuck retry counter or a wrong reply classification changes the returned status or the frame count at the end of that request. A data accumulator that is loaded in the wrong order shows up as swapped halves on the first long or register read. Errors in phase counting show up as a wrong count of low `dsclk` cycles on a single-word resume.

// File: rtl/dlink_pkg.sv
package dlink_pkg;

    localparam int WORD_W  = 16;
    localparam int FRAME_W = WORD_W + 1;
    localparam int MAX_OUT = 5;

    localparam logic [WORD_W-1:0] CMD_NOP    = 16'h0000;
    localparam logic [WORD_W-1:0] CMD_RDMEM  = 16'h1900;
    localparam logic [WORD_W-1:0] CMD_WRMEM  = 16'h1800;
    localparam logic [WORD_W-1:0] CMD_RDREG  = 16'h2180;
    localparam logic [WORD_W-1:0] CMD_WRREG  = 16'h2080;
    localparam logic [WORD_W-1:0] CMD_RESUME = 16'h0C00;
    localparam logic [WORD_W-1:0] CMD_PRST   = 16'h0400;

    typedef enum logic [2:0] {
        OP_RDMEM  = 3'd0,
        OP_WRMEM  = 3'd1,
        OP_RDREG  = 3'd2,
        OP_WRREG  = 3'd3,
        OP_RESUME = 3'd4,
        OP_PRST   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_BERR = 2'd1,
        ST_ILL  = 2'd2,
        ST_TMO  = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        RC_DATA,
        RC_NRDY,
        RC_BERR,
        RC_ILL
    } rclass_e;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_ACK,
        RK_DATA
    } rkind_e;

    typedef struct packed {
        logic [MAX_OUT-1:0][WORD_W-1:0] words;
        logic [2:0]                     n_out;
        rkind_e                         kind;
        logic [1:0]                     n_in;
        logic                           byte_rd;
    } plan_t;

    function automatic rclass_e classify(input logic [FRAME_W-1:0] f);
        if (!f[WORD_W])                      return RC_DATA;
        else if (f[WORD_W-1:0] == 16'h0000)  return RC_NRDY;
        else if (f[WORD_W-1:0] == 16'h0001)  return RC_BERR;
        else                                 return RC_ILL;
    endfunction

    function automatic logic [WORD_W-1:0] size_code(input logic [1:0] sz);
        case (sz)
            2'd0:    return 16'h0000;
            2'd1:    return 16'h0040;
            default: return 16'h0080;
        endcase
    endfunction

endpackage

// File: rtl/dlink_plan.sv
module dlink_plan
    import dlink_pkg::*;
(
    input  logic [2:0]  op,
    input  logic [1:0]  size,
    input  logic [3:0]  rnum,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output plan_t       plan
);
    logic is_long;
    assign is_long = size[1];

    always_comb begin
        plan          = '0;
        plan.words[0] = CMD_NOP;
        plan.n_out    = 3'd1;
        plan.kind     = RK_NONE;
        case (op_e'(op))
            OP_RDMEM: begin
                plan.words[0] = CMD_RDMEM | size_code(size);
                plan.words[1] = addr[31:16];
                plan.words[2] = addr[15:0];
                plan.n_out    = 3'd3;
                plan.kind     = RK_DATA;
                plan.n_in     = is_long ? 2'd2 : 2'd1;
                plan.byte_rd  = (size == 2'd0);
            end
            OP_WRMEM: begin
                plan.words[0] = CMD_WRMEM | size_code(size);
                plan.words[1] = addr[31:16];
                plan.words[2] = addr[15:0];
                plan.kind     = RK_ACK;
                if (is_long) begin
                    plan.words[3] = wdata[31:16];
                    plan.words[4] = wdata[15:0];
                    plan.n_out    = 3'd5;
                end else begin
                    plan.words[3] = (size == 2'd0) ? {8'h00, wdata[7:0]} : wdata[15:0];
                    plan.n_out    = 3'd4;
                end
            end
            OP_RDREG: begin
                plan.words[0] = CMD_RDREG | {12'h000, rnum};
                plan.kind     = RK_DATA;
                plan.n_in     = 2'd2;
            end
            OP_WRREG: begin
                plan.words[0] = CMD_WRREG | {12'h000, rnum};
                plan.words[1] = wdata[31:16];
                plan.words[2] = wdata[15:0];
                plan.n_out    = 3'd3;
                plan.kind     = RK_ACK;
            end
            OP_RESUME: plan.words[0] = CMD_RESUME;
            OP_PRST: begin
                plan.words[0] = CMD_PRST;
                plan.kind     = RK_ACK;
            end
            default: plan.words[0] = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/dlink_phy.sv
module dlink_phy
    import dlink_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WORD_W-1:0]  tx_word,
    input  logic [DLY_W-1:0]   half,
    input  logic               dso,
    output logic               dsclk,
    output logic               dsi,
    output logic               done,
    output logic [FRAME_W-1:0] rx_frame
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

    ph_e                ph;
    logic [DLY_W-1:0]   cnt;
    logic [BIT_W-1:0]   bitn;
    logic [FRAME_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            tx_sh    <= '0;
            rx_frame <= '0;
            dsclk    <= 1'b1;
            dsi      <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: if (start) begin
                    tx_sh <= {1'b0, tx_word};
                    dsi   <= 1'b0;
                    dsclk <= 1'b0;
                    cnt   <= '0;
                    bitn  <= '0;
                    ph    <= PH_LOW;
                end
                PH_LOW: begin
                    if (cnt == half) begin
                        rx_frame <= {rx_frame[FRAME_W-2:0], dso};
                        dsclk    <= 1'b1;
                        cnt      <= '0;
                        ph       <= PH_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == half) begin
                        cnt <= '0;
                        if (bitn == LAST_BIT) begin
                            ph   <= PH_IDLE;
                            done <= 1'b1;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                            dsi   <= tx_sh[FRAME_W-2];
                            dsclk <= 1'b0;
                            ph    <= PH_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R2
    dsi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dsclk && $past(dsclk)) |-> $stable(dsi));

    // R2
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_LOW && bitn == '0) |-> !dsi);

    // R2
    rise_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dsclk) |-> $past(ph == PH_LOW));

endmodule

// File: rtl/dlink_host.sv
module dlink_host
    import dlink_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int RETRY_LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DLY_W-1:0] cfg_half,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [1:0]       req_size,
    input  logic [3:0]       req_reg,
    input  logic [31:0]      req_addr,
    input  logic [31:0]      req_wdata,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [31:0]      rsp_rdata,
    output logic             dsclk,
    output logic             dsi,
    input  logic             dso
);
    localparam int RTY_W = $clog2(RETRY_LIMIT + 1);
    localparam logic [RTY_W-1:0] RTY_MAX = RTY_W'(RETRY_LIMIT);

    typedef enum logic [1:0] {S_IDLE, S_SEND, S_POLL, S_DONE} state_e;

    state_e              state;
    plan_t               plan_c, plan_q;
    logic [2:0]          widx;
    logic [1:0]          din;
    logic [RTY_W-1:0]    rty;
    logic [31:0]         acc, next_acc;
    logic                phy_start, phy_done;
    logic [WORD_W-1:0]   phy_word;
    logic [FRAME_W-1:0]  phy_rx;
    rclass_e             cls;
    logic                last_out, accept;
    logic                fin, go;
    status_e             fin_st;
    logic [31:0]         fin_dat;
    logic [WORD_W-1:0]   go_word;

    dlink_plan u_plan (
        .op    (req_op),
        .size  (req_size),
        .rnum  (req_reg),
        .addr  (req_addr),
        .wdata (req_wdata),
        .plan  (plan_c)
    );

    dlink_phy #(.DLY_W(DLY_W)) u_phy (
        .clk      (clk),
        .rst      (rst),
        .start    (phy_start),
        .tx_word  (phy_word),
        .half     (cfg_half),
        .dso      (dso),
        .dsclk    (dsclk),
        .dsi      (dsi),
        .done     (phy_done),
        .rx_frame (phy_rx)
    );

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign cls       = classify(phy_rx);
    assign last_out  = ((widx + 3'd1) >= plan_q.n_out);
    assign next_acc  = {acc[15:0], phy_rx[WORD_W-1:0]};

    always_comb begin
        fin     = 1'b0;
        fin_st  = ST_OK;
        fin_dat = '0;
        go      = 1'b0;
        go_word = CMD_NOP;
        if (phy_done && state == S_SEND) begin
            if (!last_out) begin
                go      = 1'b1;
                go_word = plan_q.words[widx + 3'd1];
            end else if (plan_q.kind == RK_NONE) begin
                fin = 1'b1;
            end else begin
                go = 1'b1;
            end
        end else if (phy_done && state == S_POLL) begin
            case (cls)
                RC_NRDY: begin
                    if (rty == RTY_MAX) begin
                        fin    = 1'b1;
                        fin_st = ST_TMO;
                    end else begin
                        go = 1'b1;
                    end
                end
                RC_BERR: begin
                    fin    = 1'b1;
                    fin_st = ST_BERR;
                end
                RC_ILL: begin
                    fin    = 1'b1;
                    fin_st = ST_ILL;
                end
                default: begin
                    if (plan_q.kind == RK_ACK) begin
                        fin = 1'b1;
                    end else if ((din + 2'd1) == plan_q.n_in) begin
                        fin = 1'b1;
                        if (plan_q.byte_rd)
                            fin_dat = {24'h0, next_acc[7:0]};
                        else if (plan_q.n_in == 2'd2)
                            fin_dat = next_acc;
                        else
                            fin_dat = {16'h0, next_acc[15:0]};
                    end else begin
                        go = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            plan_q     <= '0;
            widx       <= '0;
            din        <= '0;
            rty        <= '0;
            acc        <= '0;
            phy_start  <= 1'b0;
            phy_word   <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= '0;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            phy_start <= accept || go;
            phy_word  <= accept ? plan_c.words[0] : go_word;
            case (state)
                S_IDLE: if (accept) begin
                    plan_q <= plan_c;
                    widx   <= '0;
                    acc    <= '0;
                    state  <= S_SEND;
                end
                S_SEND: if (phy_done && !fin) begin
                    if (!last_out) begin
                        widx <= widx + 3'd1;
                    end else begin
                        din   <= '0;
                        rty   <= '0;
                        state <= S_POLL;
                    end
                end
                S_POLL: if (phy_done && !fin) begin
                    if (cls == RC_NRDY) begin
                        rty <= rty + 1'b1;
                    end else begin
                        rty <= '0;
                        din <= din + 2'd1;
                        acc <= next_acc;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
            if (fin) begin
                state      <= S_DONE;
                rsp_valid  <= 1'b1;
                rsp_status <= fin_st;
                rsp_rdata  <= fin_dat;
            end
        end
    end

    // R1
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> dsclk);

    // R13
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R13
    rsp_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R11
    retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_POLL) |-> (rty <= RTY_MAX));

    // R12
    err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != ST_OK) |-> (rsp_rdata == 32'h0));

endmodule

// File: tb/sim_dlink_host.sv
`timescale 1ns/1ps
module sim_dlink_host;

    typedef struct packed {
        logic [2:0]       op;
        logic [1:0]       sz;
        logic [3:0]       rg;
        logic [31:0]      addr;
        logic [31:0]      wd;
        logic [3:0]       nw;
        logic [15:0]      cmd;
        logic [1:0]       st;
        logic [31:0]      rd;
        logic [0:7][16:0] rsp;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t TBL [NVEC] = '{
        '{3'd0, 2'd1, 4'd0, 32'h00123456, 32'h0, 4'd4, 16'h1940, 2'd0, 32'h0000ABCD,
          '{17'h1FFFF, 17'h10001, 17'h10000, 17'h0ABCD, 17'h0, 17'h0, 17'h0, 17'h0}},
        '{3'd0, 2'd2, 4'd0, 32'h00FFA000, 32'h0, 4'd5, 16'h1980, 2'd0, 32'h12345678,
          '{17'h0, 17'h0, 17'h0, 17'h01234, 17'h05678, 17'h0, 17'h0, 17'h0}},
        '{3'd0, 2'd0, 4'd0, 32'h00000011, 32'h0, 4'd4, 16'h1900, 2'd0, 32'h000000A5,
          '{17'h0, 17'h0, 17'h0, 17'h0FFA5, 17'h0, 17'h0, 17'h0, 17'h0}},
        '{3'd1, 2'd1, 4'd0, 32'h00040002, 32'h0000BEEF, 4'd5, 16'h1840, 2'd0, 32'h0,
          '{17'h0, 17'h10001, 17'h0, 17'h0, 17'h0FFFF, 17'h0, 17'h0, 17'h0}},
        '{3'd1, 2'd2, 4'd0, 32'h00040004, 32'hCAFEF00D, 4'd6, 16'h1880, 2'd0, 32'h0,
          '{17'h0, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0FFFF, 17'h0, 17'h0}},
        '{3'd2, 2'd0, 4'd9, 32'h0, 32'h0, 4'd3, 16'h2189, 2'd0, 32'hDEADBEEF,
          '{17'h0, 17'h0DEAD, 17'h0BEEF, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0}},
        '{3'd3, 2'd0, 4'd2, 32'h0, 32'h01020304, 4'd4, 16'h2082, 2'd0, 32'h0,
          '{17'h0, 17'h0, 17'h0, 17'h0FFFF, 17'h0, 17'h0, 17'h0, 17'h0}},
        '{3'd4, 2'd0, 4'd0, 32'h0, 32'h0, 4'd1, 16'h0C00, 2'd0, 32'h0,
          '{17'h0, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0}},
        '{3'd5, 2'd0, 4'd0, 32'h0, 32'h0, 4'd2, 16'h0400, 2'd0, 32'h0,
          '{17'h0, 17'h0FFFF, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0}},
        '{3'd0, 2'd1, 4'd0, 32'h00000100, 32'h0, 4'd6, 16'h1940, 2'd0, 32'h00001111,
          '{17'h0, 17'h0, 17'h0, 17'h10000, 17'h10000, 17'h01111, 17'h0, 17'h0}},
        '{3'd0, 2'd1, 4'd0, 32'h00000200, 32'h0, 4'd4, 16'h1940, 2'd1, 32'h0,
          '{17'h0, 17'h0, 17'h0, 17'h10001, 17'h0, 17'h0, 17'h0, 17'h0}},
        '{3'd1, 2'd0, 4'd0, 32'h00000300, 32'h0000005A, 4'd5, 16'h1800, 2'd2, 32'h0,
          '{17'h0, 17'h0, 17'h0, 17'h0, 17'h1FFFF, 17'h0, 17'h0, 17'h0}},
        '{3'd0, 2'd1, 4'd0, 32'h00000400, 32'h0, 4'd8, 16'h1940, 2'd3, 32'h0,
          '{17'h0, 17'h0, 17'h0, 17'h10000, 17'h10000, 17'h10000, 17'h10000, 17'h10000}}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_half = 8'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_size = '0;
    logic [3:0]  req_reg = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;
    logic        dsclk, dsi, dso;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    logic [16:0] resp [8];
    logic [16:0] cap [16];
    logic [16:0] tout = '0;
    logic [16:0] tsh = '0;
    int          tbit = 0;
    int          cap_n = 0;
    int          lowcnt = 0;
    vec_t        v;

    always #2 clk = ~clk;

    dlink_host u0 (
        .clk        (clk),
        .rst        (rst),
        .cfg_half   (cfg_half),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_size   (req_size),
        .req_reg    (req_reg),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_rdata  (rsp_rdata),
        .dsclk      (dsclk),
        .dsi        (dsi),
        .dso        (dso)
    );

    // target model: latch on rising edge, present next reply bit afterwards
    assign dso = tout[16];
    always @(posedge dsclk) begin
        if (!rst) begin
            tsh = {tsh[15:0], dsi};
            tbit = tbit + 1;
            if (tbit == 17) begin
                if (cap_n < 16) cap[cap_n] = tsh;
                cap_n = cap_n + 1;
                tbit = 0;
                tout = (cap_n < 8) ? resp[cap_n] : 17'h0;
            end else begin
                tout = {tout[15:0], 1'b0};
            end
        end
    end

    always @(negedge clk) if (!rst && !dsclk) lowcnt = lowcnt + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    task automatic run_vec(input int idx);
        int t;
        logic hi_bits;
        v = TBL[idx];
        for (int k = 0; k < 8; k++) resp[k] = v.rsp[k];
        tout = v.rsp[0];
        tbit = 0;
        cap_n = 0;
        for (int k = 0; k < 16; k++) cap[k] = '0;
        @(negedge clk);
        lowcnt = 0;
        req_op = v.op; req_size = v.sz; req_reg = v.rg;
        req_addr = v.addr; req_wdata = v.wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk($sformatf("R13 ready low while busy v%0d", idx), {31'b0, req_ready}, 32'd0);
        t = 0;
        while (!rsp_valid && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk($sformatf("R13 response given v%0d", idx), {31'b0, rsp_valid}, 32'd1);
        chk($sformatf("R9 R10 R11 R12 status v%0d", idx), {30'b0, rsp_status}, {30'b0, v.st});
        chk($sformatf("R8 R12 rdata v%0d", idx), rsp_rdata, v.rd);
        chk($sformatf("R7 frame count v%0d", idx), cap_n, {28'b0, v.nw});
        chk($sformatf("R3 R5 R6 command word v%0d", idx), {15'b0, cap[0]}, {16'b0, v.cmd});
        hi_bits = 1'b0;
        for (int k = 0; k < 16; k++) if (k < cap_n) hi_bits = hi_bits | cap[k][16];
        chk($sformatf("R2 bit16 clear v%0d", idx), {31'b0, hi_bits}, 32'd0);
        @(negedge clk);
        chk($sformatf("R13 one-cycle strobe v%0d", idx), {31'b0, rsp_valid}, 32'd0);
    endtask

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk("R1 dsclk idle high", {31'b0, dsclk}, 32'd1);
        chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R1 no response after reset", {31'b0, rsp_valid}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(i);
            case (i)
                0: begin
                    chk("R3 address high word", {15'b0, cap[1]}, 32'h0012);
                    chk("R3 address low word", {15'b0, cap[2]}, 32'h3456);
                    chk("R7 null poll word", {15'b0, cap[3]}, 32'h0);
                end
                3: chk("R4 word write data", {15'b0, cap[3]}, 32'hBEEF);
                4: begin
                    chk("R4 long write high data", {15'b0, cap[3]}, 32'hCAFE);
                    chk("R4 long write low data", {15'b0, cap[4]}, 32'hF00D);
                end
                6: begin
                    chk("R5 reg write high data", {15'b0, cap[1]}, 32'h0102);
                    chk("R5 reg write low data", {15'b0, cap[2]}, 32'h0304);
                end
                7: chk("R2 low phase cycles over one frame", lowcnt, 32'd34);
                9: begin
                    chk("R10 repoll word 1", {15'b0, cap[4]}, 32'h0);
                    chk("R10 repoll word 2", {15'b0, cap[5]}, 32'h0);
                end
                11: chk("R4 byte write data", {15'b0, cap[3]}, 32'h005A);
                default: ;
            endcase
        end

        chk("R1 ready at end", {31'b0, req_ready}, 32'd1);
        chk("R1 dsclk high at end", {31'b0, dsclk}, 32'd1);
        summary();
    end

endmodule